// File: doc/BRIEF.md
# Chirping NCO Phase Generator

This block produces the phase word that drives a quadrature sine/cosine lookup in a down-conversion path. A 33-bit phase accumulator is decremented once per clock by the current phase step, so the rotating vector it describes turns clockwise. The upper 18 bits of the accumulator leave the block as the phase word. A registered flag marks each clock in which the decrement wrapped below zero.

The phase step comes from a second register, which follows one of four sweep modes. In the constant-tone mode the step is fixed at the lower bound. In the rising sweep it climbs by a delta each clock and restarts at the lower bound. In the falling sweep it drops by the delta and restarts at the upper bound. In the triangular sweep it rises, then falls, and then starts over. The first clock after reset is released loads the start phase and the first step. All sweep parameters are assumed stable while the block runs. They are changed only under reset.

Top module: `chirp_phase_gen`

## Requirements
- R1: While `rst_n` is low, `phase_word` and `phase_wrap` are both 0.
- R2: On the first rising clock edge with `rst_n` high, the accumulator is loaded with `phase_offset` in its 18 upper bits and zeros in its 15 lower bits, and `phase_wrap` is 0. The step register takes its start value in the same edge: `inc_max` in mode 2'b10, and `inc_min` in every other mode.
- R3: On every later edge, the accumulator becomes its old value minus the zero-extended 32-bit step, modulo 2^33. `phase_word` is accumulator bits 32..15.
- R4: After each such step, `phase_wrap` is 1 exactly when the unsigned 33-bit subtraction of that step borrowed, that is, when the old accumulator was smaller than the step.
- R5: Mode 2'b00 (constant tone): the step equals `inc_min` on every clock. `inc_max` and `inc_delta` have no effect on the output.
- R6: Mode 2'b01 (rising sweep): the candidate step is the current step plus `inc_delta`. If the candidate is greater than or equal to `inc_max`, the step reloads to `inc_min`. Otherwise the step becomes the candidate.
- R7: Mode 2'b10 (falling sweep): the candidate step is the current step minus `inc_delta`. If the candidate is below `inc_min`, including a negative result, the step reloads to `inc_max`. Otherwise the step becomes the candidate, so a value equal to `inc_min` is allowed.
- R8: Mode 2'b11 (triangular sweep): the step rises as in R6. When the rising candidate would reach `inc_max`, the step instead falls by `inc_delta`. It keeps falling until a falling candidate is at or below `inc_min`. At that point the step becomes `inc_min` and rising resumes. A direction flag tracks the sweep.
- R9: The delta is added to and subtracted from the full 32-bit step, with carries and borrows passing above bit 23.
- R10: Reset clears the sweep direction, so after any reset a triangular sweep begins by rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Sweep mode: 00 constant, 01 rising, 10 falling, 11 triangular |
| phase_offset | input | 18 | Start phase loaded into the accumulator's upper bits |
| inc_min | input | 32 | Lower bound of the phase step |
| inc_max | input | 32 | Upper bound of the phase step |
| inc_delta | input | 24 | Change of the phase step per clock in sweep modes |
| phase_word | output | 18 | Upper 18 bits of the phase accumulator |
| phase_wrap | output | 1 | Borrow out of the most recent accumulator step |

## Verification
The start phase appears on `phase_word` one edge after `rst_n` rises. It is sampled at the falling edge that follows that edge. After that, every rising edge moves the accumulator by the step held before the edge. The step computed in an edge only affects `phase_word` one edge later. `phase_wrap` belongs to the same edge as the accumulator value it accompanies. The bench advances its model once per falling edge and compares both outputs there, so the one-edge lag of the step register is matched exactly. Each sweep is run for more than two full periods, including runs where the bound is met exactly and runs where it is crossed.

// File: rtl/chirp_phase_gen.sv
module chirp_phase_gen #(
  parameter int PHASE_W = 33,
  parameter int WORD_W  = 18,
  parameter int DELTA_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic [WORD_W-1:0]  phase_offset,
  input  logic [PHASE_W-2:0] inc_min,
  input  logic [PHASE_W-2:0] inc_max,
  input  logic [DELTA_W-1:0] inc_delta,
  output logic [WORD_W-1:0]  phase_word,
  output logic               phase_wrap
);
  localparam int INC_W = PHASE_W - 1;
  localparam int LOW_W = PHASE_W - WORD_W;
  localparam int PAD_W = INC_W + 1 - DELTA_W;

  localparam logic [1:0] M_CW   = 2'b00;
  localparam logic [1:0] M_UP   = 2'b01;
  localparam logic [1:0] M_DOWN = 2'b10;
  localparam logic [1:0] M_TRI  = 2'b11;

  logic [PHASE_W-1:0] acc_q;
  logic [INC_W-1:0]   inc_q, inc_n;
  logic               run_q, fall_q, fall_n, wrap_q;

  wire [PHASE_W-1:0] acc_step = acc_q - {1'b0, inc_q};
  wire               borrow   = acc_q < {1'b0, inc_q};

  wire [INC_W:0] delta_x = {{PAD_W{1'b0}}, inc_delta};
  wire [INC_W:0] rise    = {1'b0, inc_q} + delta_x;
  wire [INC_W:0] sink    = {1'b0, inc_q} - delta_x;

  wire rise_hit   = rise >= {1'b0, inc_max};
  wire sink_below = sink[INC_W] || (sink[INC_W-1:0] <  inc_min);
  wire sink_floor = sink[INC_W] || (sink[INC_W-1:0] <= inc_min);

  wire [INC_W-1:0] inc_start = (mode == M_DOWN) ? inc_max : inc_min;

  always_comb begin
    inc_n  = inc_q;
    fall_n = fall_q;
    case (mode)
      M_CW:   inc_n = inc_min;
      M_UP:   inc_n = rise_hit ? inc_min : rise[INC_W-1:0];
      M_DOWN: inc_n = sink_below ? inc_max : sink[INC_W-1:0];
      default: begin
        if (!fall_q) begin
          if (!rise_hit) begin
            inc_n = rise[INC_W-1:0];
          end else if (sink_floor) begin
            inc_n = inc_min;
          end else begin
            inc_n  = sink[INC_W-1:0];
            fall_n = 1'b1;
          end
        end else if (sink_floor) begin
          inc_n  = inc_min;
          fall_n = 1'b0;
        end else begin
          inc_n = sink[INC_W-1:0];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      inc_q  <= '0;
      run_q  <= 1'b0;
      fall_q <= 1'b0;
      wrap_q <= 1'b0;
    end else if (!run_q) begin
      acc_q  <= {phase_offset, {LOW_W{1'b0}}};
      inc_q  <= inc_start;
      run_q  <= 1'b1;
      fall_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      acc_q  <= acc_step;
      inc_q  <= inc_n;
      fall_q <= fall_n;
      wrap_q <= borrow;
    end
  end

  assign phase_word = acc_q[PHASE_W-1 -: WORD_W];
  assign phase_wrap = wrap_q;

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (phase_word == $past(phase_offset)) && !phase_wrap);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (acc_q == $past(acc_q) - {1'b0, $past(inc_q)}));

  assert_cw_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode == M_CW) |-> (inc_q == inc_min));

  assert_rise_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode == M_UP && inc_min < inc_max) |-> (inc_q >= inc_min && inc_q < inc_max));

  assert_fall_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode == M_DOWN && inc_min <= inc_max) |-> (inc_q >= inc_min && inc_q <= inc_max));

  assert_dir_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (mode == M_TRI));

  assert_dir_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !fall_q);
endmodule

// File: tb/chirp_phase_gen_test.sv
module chirp_phase_gen_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [17:0] phase_offset = '0;
  logic [31:0] inc_min = '0;
  logic [31:0] inc_max = '0;
  logic [23:0] inc_delta = '0;
  logic [17:0] phase_word;
  logic        phase_wrap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [32:0] m_acc;
  logic [31:0] m_inc;
  logic        m_fall;
  logic        m_wrap;

  chirp_phase_gen uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .phase_offset(phase_offset),
    .inc_min(inc_min), .inc_max(inc_max), .inc_delta(inc_delta),
    .phase_word(phase_word), .phase_wrap(phase_wrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [17:0] pw, input logic wr);
    checks++;
    if (phase_word !== pw || phase_wrap !== wr) begin
      fails++;
      $display("FAIL %s: phase_word=%h wrap=%b expected phase_word=%h wrap=%b",
               tag, phase_word, phase_wrap, pw, wr);
    end
  endtask

  task automatic model_step(input logic [1:0] md, input logic [31:0] mn,
                            input logic [31:0] mx, input logic [23:0] dl);
    logic [32:0] up, dn;
    m_wrap = m_acc < {1'b0, m_inc};
    m_acc  = m_acc - {1'b0, m_inc};
    up = {1'b0, m_inc} + {9'b0, dl};
    dn = {1'b0, m_inc} - {9'b0, dl};
    case (md)
      2'b00: m_inc = mn;
      2'b01: m_inc = (up >= {1'b0, mx}) ? mn : up[31:0];
      2'b10: m_inc = (dn[32] || dn[31:0] < mn) ? mx : dn[31:0];
      default: begin
        if (!m_fall) begin
          if (up < {1'b0, mx}) m_inc = up[31:0];
          else if (dn[32] || dn[31:0] <= mn) m_inc = mn;
          else begin m_inc = dn[31:0]; m_fall = 1'b1; end
        end else if (dn[32] || dn[31:0] <= mn) begin
          m_inc = mn; m_fall = 1'b0;
        end else m_inc = dn[31:0];
      end
    endcase
  endtask

  task automatic run_mode(input string tag, input logic [1:0] md, input logic [17:0] off,
                          input logic [31:0] mn, input logic [31:0] mx,
                          input logic [23:0] dl, input int steps);
    @(negedge clk);
    rst_n = 1'b0;
    mode = md; phase_offset = off; inc_min = mn; inc_max = mx; inc_delta = dl;
    @(negedge clk);
    @(negedge clk);
    check({tag, " R1 reset"}, 18'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    m_acc  = {off, 15'b0};
    m_inc  = (md == 2'b10) ? mx : mn;
    m_fall = 1'b0;
    m_wrap = 1'b0;
    check({tag, " R2 load"}, m_acc[32:15], m_wrap);
    for (int i = 0; i < steps; i++) begin
      @(negedge clk);
      model_step(md, mn, mx, dl);
      check({tag, " R3 R4 step"}, m_acc[32:15], m_wrap);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    run_mode("R5 constant", 2'b00, 18'h2A5C3, 32'h0123_4567, 32'h0000_0000, 24'hFFFFFF, 12);
    run_mode("R5 R4 constant wrap", 2'b00, 18'h00010, 32'hF000_0000, 32'h1000_0000, 24'h000001, 20);
    run_mode("R6 rising meet", 2'b01, 18'h3FFFF, 32'h0400_0000, 32'h0680_0000, 24'h40_0000, 30);
    run_mode("R6 rising cross", 2'b01, 18'h12345, 32'h0400_0000, 32'h0660_0000, 24'h40_0000, 30);
    run_mode("R7 falling meet", 2'b10, 18'h00000, 32'h0400_0000, 32'h0680_0000, 24'h40_0000, 30);
    run_mode("R7 falling cross", 2'b10, 18'h1F000, 32'h0420_0000, 32'h0680_0000, 24'h40_0000, 30);
    run_mode("R7 falling negative", 2'b10, 18'h0ABCD, 32'h0000_0000, 32'h0050_0000, 24'h30_0000, 12);
    run_mode("R9 rising carry", 2'b01, 18'h05555, 32'h00FF_0000, 32'h0800_0000, 24'hFF_0000, 30);
    run_mode("R9 falling borrow", 2'b10, 18'h2AAAA, 32'h0010_0000, 32'h0300_0000, 24'hF0_0000, 20);
    run_mode("R8 triangular", 2'b11, 18'h20000, 32'h0400_0000, 32'h0680_0000, 24'h40_0000, 60);
    run_mode("R8 triangular cross", 2'b11, 18'h01234, 32'h0420_0000, 32'h0660_0000, 24'h40_0000, 50);
    run_mode("R10 stop mid fall", 2'b11, 18'h3C000, 32'h0400_0000, 32'h0680_0000, 24'h40_0000, 15);
    run_mode("R10 restart rising", 2'b11, 18'h3C000, 32'h0400_0000, 32'h0680_0000, 24'h40_0000, 25);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule